// File: doc/BRIEF.md
# Converter Output Stage with Guard-Band Overrange Flag

This block is the digital back end of a 16-bit pipelined converter. On every rising clock edge it takes one raw offset-binary code. It carries that code through a fixed pipeline of six register stages, then presents it on a parallel data bus. An overrange bit rides through the pipeline with the code and leaves on the same cycle.

The overrange bit is computed when the code enters the pipeline. It flags a guard band of 1024 codes at each end of the scale, not only the two extreme codes. An active-high output enable puts both the data bus and the overrange bit into a high-impedance state, and it leaves the pipeline contents untouched.

A synchronous flush, or the synchronous reset, marks every word in flight as invalid. The valid flag stays low until six fresh samples have entered the pipeline.

Top module: `cvt_output_stage`

## Requirements
- R1: A code presented on `sample_in` in cycle c is captured on the next rising edge and appears on `data_out` in cycle c+6, which is six register stages later.
- R2: The code comes out unchanged as offset binary. Bit 15 is the MSB and bit 0 is the LSB, and no bit is reordered or inverted.
- R3: `ovr_out` is 1 for a word whose code is 0xFC00 or greater.
- R4: `ovr_out` is 1 for a word whose code is 0x03FF or less.
- R5: `ovr_out` is 0 for every code from 0x0400 to 0xFBFF inclusive.
- R6: `ovr_out` belongs to the code on `data_out` in the same cycle. It is never the flag of a neighbouring sample.
- R7: While `out_en` is 0, `data_out` and `ovr_out` are high-impedance. While `out_en` is 1, both are driven. The change takes effect in the same cycle, with no clock edge needed.
- R8: `out_en` has no effect on the pipeline. Words that are in flight while the bus is disabled come out intact once it is enabled again.
- R9: `flush`=1 in cycle f makes `word_valid` 0 in cycles f+1 to f+6. `word_valid` returns to 1 in cycle f+7, provided no further flush or reset arrives in that window.
- R10: `rst` is synchronous and active high and has the same effect as `flush`. `word_valid` is 0 during reset and for six cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous pipeline invalidate |
| sample_in | input | 16 | Raw offset-binary code |
| out_en | input | 1 | Bus drive enable, active high |
| data_out | output | 16 | Delayed code, high-impedance when disabled |
| ovr_out | output | 1 | Overrange flag of the delayed code, high-impedance when disabled |
| word_valid | output | 1 | Output word comes from a sample taken since the last flush or reset |

## Verification
A flush can arrive in the same cycle as a change of output enable, or while the bus is already disabled. Either could wrongly gate the invalidation or disturb the words in flight. The stimulus drops `out_en` at random, sometimes across a flush and across the guard-band boundary codes 0x03FF, 0x0400, 0xFBFF and 0xFC00. The outcome is judged at the ports. The valid flag must follow the flush timing whatever the enable does. Each word that leaves once the bus is enabled again must carry the code and flag that a cycle-count model of the input history predicts.

// File: rtl/cvt_out_pkg.sv
package cvt_out_pkg;

    localparam int CODE_W = 16;

    // One pipeline entry: validity, overrange flag and the code itself.
    typedef struct packed {
        logic              vld;
        logic              ovr;
        logic [CODE_W-1:0] code;
    } cvt_word_t;

    // True when the code lies in either guard band.
    function automatic logic in_guard_band(
        input logic [CODE_W-1:0] code,
        input logic [CODE_W-1:0] lo_limit,
        input logic [CODE_W-1:0] hi_limit
    );
        return (code >= hi_limit) || (code <= lo_limit);
    endfunction

endpackage

// File: rtl/cvt_range_flag.sv
module cvt_range_flag
    import cvt_out_pkg::*;
#(
    parameter int GUARD_CODES = 1024
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              ovr_o
);
    localparam logic [CODE_W:0]   FULL     = (CODE_W+1)'(1) << CODE_W;
    localparam logic [CODE_W-1:0] LO_LIMIT = CODE_W'(GUARD_CODES - 1);
    localparam logic [CODE_W-1:0] HI_LIMIT = CODE_W'(FULL - (CODE_W+1)'(GUARD_CODES));

    always_comb begin
        ovr_o = in_guard_band(code_i, LO_LIMIT, HI_LIMIT);
    end
endmodule

// File: rtl/cvt_delay_line.sv
module cvt_delay_line
    import cvt_out_pkg::*;
#(
    parameter int STAGES = 6
) (
    input  logic      clk,
    input  logic      kill_i,
    input  cvt_word_t word_i,
    output cvt_word_t word_o
);
    cvt_word_t stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        cvt_word_t prev;
        if (s == 0) begin : g_head
            assign prev = word_i;
        end else begin : g_body
            assign prev = stage_q[s-1];
        end

        always_ff @(posedge clk) begin
            stage_q[s].code <= prev.code;
            stage_q[s].ovr  <= prev.ovr;
            stage_q[s].vld  <= kill_i ? 1'b0 : prev.vld;
        end
    end

    assign word_o = stage_q[STAGES-1];
endmodule

// File: rtl/cvt_output_stage.sv
module cvt_output_stage
    import cvt_out_pkg::*;
#(
    parameter int LATENCY     = 6,
    parameter int GUARD_CODES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [CODE_W-1:0] sample_in,
    input  logic              out_en,
    output logic [CODE_W-1:0] data_out,
    output logic              ovr_out,
    output logic              word_valid
);
    logic              head_ovr;
    cvt_word_t         head_word;
    cvt_word_t         tail_word;
    logic              kill;
    logic [CODE_W-1:0] tail_code;
    logic              tail_ovr;

    assign kill = rst | flush;

    cvt_range_flag #(.GUARD_CODES(GUARD_CODES)) i_range (
        .code_i (sample_in),
        .ovr_o  (head_ovr)
    );

    always_comb begin
        head_word.vld  = 1'b1;
        head_word.ovr  = head_ovr;
        head_word.code = sample_in;
    end

    cvt_delay_line #(.STAGES(LATENCY)) i_delay (
        .clk    (clk),
        .kill_i (kill),
        .word_i (head_word),
        .word_o (tail_word)
    );

    assign tail_code  = tail_word.code;
    assign tail_ovr   = tail_word.ovr;
    assign word_valid = tail_word.vld;

    assign data_out = out_en ? tail_code : {CODE_W{1'bz}};
    assign ovr_out  = out_en ? tail_ovr  : 1'bz;
endmodule

// File: rtl/cvt_output_stage_chk.sv
module cvt_output_stage_chk
    import cvt_out_pkg::*;
#(
    parameter int LATENCY = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic [CODE_W-1:0] sample_in,
    input logic [CODE_W-1:0] tail_code,
    input logic              tail_ovr,
    input logic              word_valid
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CODE_W-1:0] mdl_q [LATENCY];
    logic [CNT_W-1:0]  fill_q;

    always_ff @(posedge clk) begin
        mdl_q[0] <= sample_in;
        for (int i = 1; i < LATENCY; i++) mdl_q[i] <= mdl_q[i-1];
        if (rst || flush)                  fill_q <= '0;
        else if (fill_q != CNT_W'(LATENCY)) fill_q <= fill_q + 1'b1;
    end

    AST_LATENCY_CODE: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> tail_code == mdl_q[LATENCY-1]);                      // R1
    AST_GUARD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (word_valid && tail_code >= 16'hFC00) |-> tail_ovr);                // R3
    AST_GUARD_LOW: assert property (@(posedge clk) disable iff (rst)
        (word_valid && tail_code <= 16'h03FF) |-> tail_ovr);                // R4
    AST_MID_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (word_valid && tail_code > 16'h03FF && tail_code < 16'hFC00) |-> !tail_ovr); // R5
    AST_FLUSH_KILL: assert property (@(posedge clk) disable iff (rst)
        $past(flush) |-> !word_valid);                                      // R9
    AST_FILL_WINDOW: assert property (@(posedge clk) disable iff (rst)
        word_valid == (fill_q == CNT_W'(LATENCY)));                         // R9
    AST_RESET_KILL: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !word_valid);                                        // R10
endmodule

bind cvt_output_stage cvt_output_stage_chk #(.LATENCY(LATENCY)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .sample_in  (sample_in),
    .tail_code  (tail_code),
    .tail_ovr   (tail_ovr),
    .word_valid (word_valid)
);

// File: tb/test_cvt_output_stage.sv
module test_cvt_output_stage;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic [15:0] sample_in = '0;
    logic        out_en = 1'b1;
    logic [15:0] data_out;
    logic        ovr_out;
    logic        word_valid;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_kill = 0;
    bit done  = 0;
    logic [15:0] hist [8];

    always #2.5 clk = ~clk;

    cvt_output_stage i_cvt_output_stage (
        .clk(clk), .rst(rst), .flush(flush), .sample_in(sample_in),
        .out_en(out_en), .data_out(data_out), .ovr_out(ovr_out),
        .word_valid(word_valid)
    );

    function automatic logic exp_ovr(input logic [15:0] c);
        return (c >= 16'hFC00) || (c <= 16'h03FF);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic chk_undriven(input string req, input logic [15:0] act, input logic [15:0] drv);
        total++;
        if (act === drv) begin
            bad++;
            $display("FAIL %s cycle %0d: actual %h expected not driven (z)", req, cyc, act);
        end
    endtask

    // Apply inputs at the falling edge, then check outputs against the history model.
    task automatic step(input logic r, input logic f, input logic [15:0] s, input logic oe);
        logic        exp_v;
        logic [15:0] exp_c;
        @(negedge clk);
        rst = r; flush = f; sample_in = s; out_en = oe;
        #1;
        exp_v = (cyc - last_kill) >= LAT + 1;
        exp_c = hist[(cyc - LAT) & 7];
        chk(r ? "R10 valid" : "R9 valid", {15'd0, word_valid}, {15'd0, exp_v});
        if (exp_v && oe) begin
            chk("R1 R2 R8 data", data_out, exp_c);
            if (exp_ovr(exp_c) && exp_c >= 16'hFC00)
                chk("R3 R6 ovr", {15'd0, ovr_out}, 16'd1);
            else if (exp_ovr(exp_c))
                chk("R4 R6 ovr", {15'd0, ovr_out}, 16'd1);
            else
                chk("R5 R6 ovr", {15'd0, ovr_out}, 16'd0);
        end else if (exp_v && !oe) begin
            if (exp_c != 16'd0) chk_undriven("R7 data", data_out, exp_c);
            if (exp_ovr(exp_c)) chk_undriven("R7 ovr", {15'd0, ovr_out}, 16'd1);
        end
        hist[cyc & 7] = s;
        if (r || f) last_kill = cyc;
        cyc++;
    endtask

    initial begin
        int unsigned rv;
        logic [15:0] corners [8];
        corners[0] = 16'h03FF; corners[1] = 16'h0400; corners[2] = 16'hFBFF;
        corners[3] = 16'hFC00; corners[4] = 16'h0000; corners[5] = 16'hFFFF;
        corners[6] = 16'h8000; corners[7] = 16'h7FFF;
        rv = $urandom(32'd2024);
        for (int i = 0; i < 8; i++) hist[i] = '0;
        // R10 reset state
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 16'h1234, 1'b1);
        // R3 R4 R5 boundary codes, repeated to drain
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < 8; i++) step(1'b0, 1'b0, corners[i], 1'b1);
        // R7 R8: bus disabled while corner codes are in flight
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, corners[i], 1'b0);
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, corners[i] ^ 16'h0001, 1'b1);
        // R9 flush with bus disabled, then flush on enable change
        step(1'b0, 1'b1, 16'hAAAA, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 16'h5555 + 16'(i), 1'b1);
        step(1'b0, 1'b1, 16'hFC00, 1'b1);
        step(1'b0, 1'b0, 16'h03FF, 1'b0);
        step(1'b0, 1'b1, 16'h0400, 1'b1);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 16'hFBFF - 16'(i), 1'b1);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] s;
            rv = $urandom;
            s = (rv[3:0] == 4'd0) ? corners[rv[6:4]] : 16'($urandom);
            step(1'b0, ($urandom % 40) == 0, s, ($urandom % 5) != 0);
        end
        // R10 mid-run reset
        step(1'b1, 1'b0, 16'h0001, 1'b1);
        for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 16'h4000 + 16'(i), 1'b1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule